// File: doc/BRIEF.md
# Coarse-Fine Approach-From-Above Adjuster

This block walks a 12-bit working value down onto a target. While idle it keeps loading a starting value and a target from its inputs. A start request moves it into the adjusting phase. In that phase it takes coarse steps of 100 downward, one per clock, until the value either lands on the target or drops below it. If the value drops below the target, it then takes fine steps of 10 upward, one per clock, until the value is back at or above the target.

The result is the first value on that path that is not below the target. A flag records whether the fine phase was ever entered. The block holds the result and the flag in its finished state until an acknowledge returns it to idle. The state is exposed as three one-hot outputs, so a host can poll for completion.

Top module: `approach_adjuster`

## Requirements
- R1: The state outputs are one-hot, with idle = {q_done,q_adj,q_init} 3'b001, adjusting = 3'b010 and finished = 3'b100. A synchronous active-high reset forces idle and clears a_out and flag to 0.
- R2: In idle, every clock loads a_out from a_in and the target from b_in, and clears flag. The first adjusting cycle shows the a_in that was present on the start clock.
- R3: In adjusting, when the working value is above the target and flag is clear, the value drops by 100 on the next clock.
- R4: In adjusting, when the working value is below the target, the value rises by 10 on the next clock and flag becomes 1.
- R5: Adjusting moves to finished in a clock where the value equals the target, or where flag is set and the value is above the target. That decision clock counts as an adjusting clock. For a target of 312, starting values 768, 712 and 702 spend 11, 5 and 6 clocks in adjusting.
- R6: In finished, a_out and flag hold while ack is low. An ack sampled high returns the block to idle on the next clock.
- R7: On reaching finished, a_out is not below the target. It equals the target when flag is 0, and lies less than 10 above the target when flag is 1.
- R8: In idle with start low, the block stays in idle.
- R9: When the starting value equals the target, the block spends exactly one clock in adjusting and finishes with a_out equal to the target and flag 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Leave idle and begin adjusting |
| ack | input | 1 | Leave finished and return to idle |
| a_in | input | 12 | Starting value |
| b_in | input | 12 | Target value |
| a_out | output | 12 | Working value / result |
| flag | output | 1 | Set once a fine step has been taken |
| q_init | output | 1 | Idle state |
| q_adj | output | 1 | Adjusting state |
| q_done | output | 1 | Finished state |

## Verification
The step and result properties assume that the starting value is at or above the target. They also assume that the target is at least 100, so a coarse step never wraps below zero, and at most 4085, so a fine step never wraps past the top of the range. Every case the stimulus drives obeys these three limits. The cases include exact landings, a start equal to the target, a start one above the target that needs a long fine phase, and values near both ends of the range. Start and ack are only pulsed while the block sits in the state that consumes them.

// File: rtl/adj_pkg.sv
package adj_pkg;
  typedef enum logic [2:0] {
    ST_INIT = 3'b001,
    ST_ADJ  = 3'b010,
    ST_DONE = 3'b100
  } adj_state_e;
endpackage

// File: rtl/adj_compare.sv
module adj_compare #(
  parameter int W = 12
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         eq,
  output logic         gt,
  output logic         lt
);
  always_comb begin
    eq = (a == b);
    gt = (a > b);
    lt = (a < b);
  end
endmodule

// File: rtl/adj_ctrl.sv
module adj_ctrl
  import adj_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       ack,
  input  logic       eq,
  input  logic       gt,
  input  logic       flag_q,
  output adj_state_e state
);
  adj_state_e nxt;
  logic       finish;

  assign finish = eq | (flag_q & gt);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_INIT: if (start)  nxt = ST_ADJ;
      ST_ADJ:  if (finish) nxt = ST_DONE;
      ST_DONE: if (ack)    nxt = ST_INIT;
      default: nxt = ST_INIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_INIT;
    else     state <= nxt;
  end

  // R1
  state_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot(state));

  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE && !ack) |=> (state == ST_DONE));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_INIT && !start) |=> (state == ST_INIT));

  // R5
  adj_stay_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADJ && !eq && !(flag_q && gt)) |=> (state == ST_ADJ));
endmodule

// File: rtl/adj_datapath.sv
module adj_datapath #(
  parameter int W      = 12,
  parameter int COARSE = 100,
  parameter int FINE   = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_init,
  input  logic         in_adj,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_q,
  output logic [W-1:0] b_q,
  output logic         flag_q
);
  localparam logic [W-1:0] COARSE_V = W'(COARSE);
  localparam logic [W-1:0] FINE_V   = W'(FINE);

  logic eq, gt, lt;

  adj_compare #(.W(W)) u_cmp (
    .a  (a_q),
    .b  (b_q),
    .eq (eq),
    .gt (gt),
    .lt (lt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q    <= '0;
      b_q    <= '0;
      flag_q <= 1'b0;
    end else if (in_init) begin
      a_q    <= a_in;
      b_q    <= b_in;
      flag_q <= 1'b0;
    end else if (in_adj && !eq) begin
      if (gt && !flag_q) begin
        a_q <= a_q - COARSE_V;
      end else if (lt) begin
        a_q    <= a_q + FINE_V;
        flag_q <= 1'b1;
      end
    end
  end

  // R3
  coarse_step_chk: assert property (@(posedge clk) disable iff (rst)
    (in_adj && gt && !flag_q) |=> (a_q == $past(a_q) - COARSE_V));

  // R4
  fine_step_chk: assert property (@(posedge clk) disable iff (rst)
    (in_adj && lt) |=> (a_q == $past(a_q) + FINE_V) && flag_q);

  // R6
  done_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_init && !in_adj) |=> $stable(a_q) && $stable(flag_q));
endmodule

// File: rtl/approach_adjuster.sv
module approach_adjuster
  import adj_pkg::*;
#(
  parameter int W      = 12,
  parameter int COARSE = 100,
  parameter int FINE   = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         ack,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic         flag,
  output logic         q_init,
  output logic         q_adj,
  output logic         q_done
);
  localparam logic [W-1:0] FINE_V = W'(FINE);

  adj_state_e  state;
  logic [W-1:0] a_q, b_q;
  logic         flag_q;
  logic         eq, gt, lt;

  adj_compare #(.W(W)) u_top_cmp (
    .a  (a_q),
    .b  (b_q),
    .eq (eq),
    .gt (gt),
    .lt (lt)
  );

  adj_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .ack    (ack),
    .eq     (eq),
    .gt     (gt),
    .flag_q (flag_q),
    .state  (state)
  );

  adj_datapath #(.W(W), .COARSE(COARSE), .FINE(FINE)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .in_init (state == ST_INIT),
    .in_adj  (state == ST_ADJ),
    .a_in    (a_in),
    .b_in    (b_in),
    .a_q     (a_q),
    .b_q     (b_q),
    .flag_q  (flag_q)
  );

  assign a_out  = a_q;
  assign flag   = flag_q;
  assign q_init = state[0];
  assign q_adj  = state[1];
  assign q_done = state[2];

  // R7
  result_range_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(q_done) |-> !lt && (flag_q ? ((a_q - b_q) < FINE_V) : eq));

  // R9
  equal_start_chk: assert property (@(posedge clk) disable iff (rst)
    (q_adj && eq && !flag_q) |=> q_done && $stable(a_q) && !flag_q);
endmodule

// File: tb/sim_approach_adjuster.sv
module sim_approach_adjuster;
  logic        clk = 1'b0;
  logic        rst, start, ack;
  logic [11:0] a_in, b_in, a_out;
  logic        flag, q_init, q_adj, q_done;

  always #2.5 clk = ~clk;

  approach_adjuster u0 (
    .clk(clk), .rst(rst), .start(start), .ack(ack),
    .a_in(a_in), .b_in(b_in), .a_out(a_out), .flag(flag),
    .q_init(q_init), .q_adj(q_adj), .q_done(q_done)
  );

  typedef struct {
    int ain; int bin; int exp_a; int exp_f; int exp_n;
  } case_t;

  case_t sb[$];
  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // reference walk of the adjustment, from the requirements
  task automatic model(input int ain, input int bin, output case_t c);
    int a = ain;
    int f = 0;
    int n = 0;
    while (1) begin
      n++;
      if (a == bin || (f == 1 && a > bin)) break;
      if (a > bin && f == 0) a -= 100;
      else begin a += 10; f = 1; end
    end
    c.ain = ain; c.bin = bin; c.exp_a = a; c.exp_f = f; c.exp_n = n;
  endtask

  task automatic run_case(input int ain, input int bin);
    case_t c;
    model(ain, bin, c);
    sb.push_back(c);
    @(negedge clk);
    a_in = 12'(ain); b_in = 12'(bin); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!q_done) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(q_done && a_out == 12'(c.exp_a) && flag == c.exp_f[0], "R6 hold in finished",
          int'(a_out), c.exp_a);
    end
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk(q_init && !q_adj && !q_done, "R6 ack to idle", {q_done, q_adj, q_init}, 1);
  endtask

  // monitor: step-by-step trace and scoreboard of finished results
  initial begin
    int  prev_a = 0;
    bit  prev_f = 0;
    bit  prev_adj = 0;
    bit  was_done = 0;
    int  n = 0;
    int  exp_a;
    case_t item;
    forever begin
      @(posedge clk); #1;
      if (rst) begin
        prev_adj = 0; n = 0; was_done = 0;
      end else begin
        if (q_adj && sb.size() > 0) begin
          if (!prev_adj) begin
            chk(a_out == 12'(sb[0].ain), "R2 load of a_in", int'(a_out), sb[0].ain);
          end else if (prev_a > sb[0].bin && !prev_f) begin
            exp_a = prev_a - 100;
            chk(a_out == 12'(exp_a) && !flag, "R3 coarse step", int'(a_out), exp_a);
          end else if (prev_a < sb[0].bin) begin
            exp_a = prev_a + 10;
            chk(a_out == 12'(exp_a) && flag, "R4 fine step", int'(a_out), exp_a);
          end
          n++;
          prev_adj = 1; prev_a = int'(a_out); prev_f = flag;
        end else begin
          prev_adj = 0;
        end
        if (q_done && !was_done && sb.size() > 0) begin
          item = sb.pop_front();
          chk(a_out == 12'(item.exp_a), "R7 result value", int'(a_out), item.exp_a);
          chk(flag == item.exp_f[0], "R7 flag value", int'(flag), item.exp_f);
          chk(n == item.exp_n, "R5 clocks in adjusting", n, item.exp_n);
          if (item.ain == item.bin)
            chk(n == 1 && !flag && a_out == 12'(item.bin), "R9 equal start", n, 1);
          n = 0;
        end
        was_done = q_done;
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  initial begin
    case_t c;
    rst = 1'b1; start = 1'b0; ack = 1'b0; a_in = '0; b_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(q_init && !q_adj && !q_done && a_out == 0 && !flag, "R1 reset state",
        {q_done, q_adj, q_init}, 1);
    rst = 1'b0;
    a_in = 12'd123; b_in = 12'd45;
    @(negedge clk);
    @(negedge clk);
    chk(q_init && a_out == 12'd123 && !flag, "R8 idle with start low", int'(a_out), 123);
    a_in = 12'd777;
    @(negedge clk);
    chk(a_out == 12'd777, "R2 idle follows a_in", int'(a_out), 777);

    // R5 worked examples, cross-checked against fixed counts
    model(768, 312, c); chk(c.exp_n == 11 && c.exp_a == 318, "R5 model 768", c.exp_n, 11);
    model(712, 312, c); chk(c.exp_n == 5 && c.exp_a == 312, "R5 model 712", c.exp_n, 5);
    model(702, 312, c); chk(c.exp_n == 6 && c.exp_a == 312, "R5 model 702", c.exp_n, 6);

    run_case(768, 312);
    run_case(712, 312);
    run_case(702, 312);
    run_case(312, 312);
    run_case(313, 312);
    run_case(4000, 100);
    run_case(1000, 995);
    run_case(205, 200);
    run_case(4085, 4085);
    run_case(4095, 4080);
    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R7 scoreboard drained", sb.size(), 0);
    finish_up();
  end
endmodule